// File: doc/BRIEF.md
# Time Base and Decrementer Unit

This block keeps a free-running 64-bit time base that counts up and a 32-bit decrementer that counts down. Both move by the same step, on the same cycles. The step comes from one of two sources, chosen by a mode input.

In gated mode, a prescaler input reports how many sixteenth-of-full-speed ticks passed during the current internal cycle. The block uses that count only while the external timing pin is high. In edge mode, each rising edge of the same pin adds exactly one count.

The internal clock can be slowed down, so one cycle may need to carry several counts to keep elapsed time correct. For the same reason, the decrementer flags an event when a step borrows past zero, not when it lands on zero. That event is a sticky pending bit, cleared by a write-1 strobe. Software can load and read both counters.

Top module: `tbdec_unit`

## Requirements
- R1: After reset, the time base reads 0, the decrementer reads all ones, and the event flag is 0.
- R2: A time base write loads `tb_wdata` exactly, taking priority over that cycle's step. Otherwise the time base adds the step each cycle, wrapping modulo 2^64.
- R3: A decrementer write loads `dec_wdata` exactly, taking priority over that cycle's step. Otherwise the decrementer subtracts the same step the time base adds, modulo 2^32.
- R4: With `ext_mode`=0, the step equals `tick_count` while the synchronised pin is high. `tick_count` values above 4 count as 4.
- R5: With `ext_mode`=0 and the synchronised pin low, the step is 0 whatever `tick_count` is.
- R6: With `ext_mode`=1, the step is 1 on each rising edge of the pin, seen after a two-flop synchroniser, and 0 otherwise. `tick_count` is ignored in this mode.
- R7: The event flag sets when the step is larger than the decrementer's current value, meaning the subtraction borrows past zero. A step that lands exactly on zero does not set it.
- R8: The event flag stays set until `evt_clr` is pulsed. If a new borrow and a clear happen in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal (possibly slowed) logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 0: gated prescaler mode, 1: pin rising-edge mode |
| tick_count | input | 3 | Sixteenth-rate ticks elapsed this cycle (0..4) |
| tb_pin | input | 1 | Asynchronous timing pin (gate or external clock) |
| tb_wr | input | 1 | Time base load strobe |
| tb_wdata | input | 64 | Time base load value |
| dec_wr | input | 1 | Decrementer load strobe |
| dec_wdata | input | 32 | Decrementer load value |
| evt_clr | input | 1 | Write-1 clear of the event flag |
| tb_value | output | 64 | Current time base |
| dec_value | output | 32 | Current decrementer |
| dec_event | output | 1 | Sticky decrementer wrap event |

## Verification
On every cycle, the assertions check the following:
- The time base and the decrementer move by equal and opposite amounts.
- Gated mode with the pin low freezes both counters.
- Edge mode never adds more than one count.
- A rise in the decrementer value without a load always leaves the event set.
- The pending flag holds until it is cleared.

Only the bench scenarios can show the exact arithmetic, by sweeping every tick count against decrementer values near zero. They also show the following:
- The clamp of out-of-range tick counts.
- The distinction between landing on zero and borrowing past it.
- The one-per-edge count over a pulse train on the pin.
- The set-over-clear ordering.

// File: rtl/tbdec_unit.sv
module tbdec_unit #(
  parameter int TB_W     = 64,
  parameter int DEC_W    = 32,
  parameter int TICK_W   = 3,
  parameter int MAX_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic [TICK_W-1:0] tick_count,
  input  logic              tb_pin,
  input  logic              tb_wr,
  input  logic [TB_W-1:0]   tb_wdata,
  input  logic              dec_wr,
  input  logic [DEC_W-1:0]  dec_wdata,
  input  logic              evt_clr,
  output logic [TB_W-1:0]   tb_value,
  output logic [DEC_W-1:0]  dec_value,
  output logic              dec_event
);

  localparam logic [TICK_W-1:0] STEP_CAP = TICK_W'(MAX_STEP);

  logic              pin_s1, pin_s2, pin_d;
  logic [TB_W-1:0]   tb_q;
  logic [DEC_W-1:0]  dec_q;
  logic              evt_q;
  logic [TICK_W-1:0] tick_sat, step;
  logic              pin_rise, borrow;
  logic [DEC_W:0]    dec_diff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_s1 <= 1'b0;
      pin_s2 <= 1'b0;
      pin_d  <= 1'b0;
    end else begin
      pin_s1 <= tb_pin;
      pin_s2 <= pin_s1;
      pin_d  <= pin_s2;
    end
  end

  assign pin_rise = pin_s2 & ~pin_d;
  assign tick_sat = (tick_count > STEP_CAP) ? STEP_CAP : tick_count;
  assign step     = ext_mode ? TICK_W'(pin_rise) : (pin_s2 ? tick_sat : '0);
  assign dec_diff = {1'b0, dec_q} - (DEC_W+1)'(step);
  assign borrow   = dec_diff[DEC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tb_q  <= '0;
      dec_q <= '1;
      evt_q <= 1'b0;
    end else begin
      tb_q  <= tb_wr  ? tb_wdata  : tb_q + TB_W'(step);
      dec_q <= dec_wr ? dec_wdata : dec_diff[DEC_W-1:0];
      if (borrow && !dec_wr) evt_q <= 1'b1;
      else if (evt_clr)      evt_q <= 1'b0;
    end
  end

  assign tb_value  = tb_q;
  assign dec_value = dec_q;
  assign dec_event = evt_q;

  always_comb begin
    a_r4_step_bound: assert (step <= STEP_CAP);
  end

  a_r3_equal_steps: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_wr && !dec_wr |=>
      (tb_q[DEC_W-1:0] - $past(tb_q[DEC_W-1:0])) == ($past(dec_q) - dec_q));

  a_r5_gate_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode && !pin_s2 && !tb_wr && !dec_wr |=> $stable(tb_q) && $stable(dec_q));

  a_r6_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode && !tb_wr |=> (tb_q - $past(tb_q)) <= TB_W'(1));

  a_r7_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_wr |=> (dec_q > $past(dec_q)) -> evt_q);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q && !evt_clr |=> evt_q);

endmodule

// File: tb/tbdec_unit_test.sv
module tbdec_unit_test;
  logic        clk = 0, rst_n = 0, ext_mode = 0, tb_pin = 0;
  logic [2:0]  tick_count = 0;
  logic        tb_wr = 0, dec_wr = 0, evt_clr = 0;
  logic [63:0] tb_wdata = 0;
  logic [31:0] dec_wdata = 0;
  logic [63:0] tb_value;
  logic [31:0] dec_value;
  logic        dec_event;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tbdec_unit uut (.clk, .rst_n, .ext_mode, .tick_count, .tb_pin, .tb_wr, .tb_wdata,
                  .dec_wr, .dec_wdata, .evt_clr, .tb_value, .dec_value, .dec_event);

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #5_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] base;
    cyc(2);
    rst_n = 1;
    cyc(1);
    check("R1 tb", tb_value, 0);
    check("R1 dec", dec_value, 32'hFFFF_FFFF);
    check("R1 evt", {63'd0, dec_event}, 0);

    tb_pin = 1;
    cyc(3);
    check("R5 no step before pin", tb_value, 0);

    // Sweep: every tick count against decrementer start values near zero.
    for (int t = 0; t < 8; t++) begin
      for (int d = 0; d < 6; d++) begin
        int s;
        s = (t > 4) ? 4 : t;
        base = 64'h1234_0000_0000_0000 + 64'(t * 16 + d);
        tb_wr = 1; tb_wdata = base; dec_wr = 1; dec_wdata = 32'(d); evt_clr = 1; tick_count = 3'(t);
        cyc(1);
        check("R2 write priority", tb_value, base);
        check("R3 write priority", {32'd0, dec_value}, 64'(d));
        tb_wr = 0; dec_wr = 0; evt_clr = 0;
        cyc(1);
        check("R4 tb step", tb_value, base + 64'(s));
        check("R3 dec step", {32'd0, dec_value}, {32'd0, 32'(d) - 32'(s)});
        check("R7 wrap event", {63'd0, dec_event}, {63'd0, s > d});
        tick_count = 0;
      end
    end

    // Time base wraps modulo 2^64 on a multi-count step.
    tb_wr = 1; tb_wdata = 64'hFFFF_FFFF_FFFF_FFFE; cyc(1);
    tb_wr = 0; tick_count = 4; cyc(1);
    check("R2 tb wrap", tb_value, 64'd2);
    tick_count = 0;

    // Sticky event and write-1 clear; set wins over a simultaneous clear.
    dec_wr = 1; dec_wdata = 1; evt_clr = 1; cyc(1);
    dec_wr = 0; evt_clr = 0; tick_count = 3; cyc(1);
    tick_count = 0;
    check("R8 event set", {63'd0, dec_event}, 1);
    cyc(4);
    check("R8 event sticky", {63'd0, dec_event}, 1);
    evt_clr = 1; cyc(1); evt_clr = 0;
    check("R8 event cleared", {63'd0, dec_event}, 0);
    dec_wr = 1; dec_wdata = 0; cyc(1);
    dec_wr = 0; tick_count = 1; evt_clr = 1; cyc(1);
    tick_count = 0; evt_clr = 0;
    check("R8 set wins over clear", {63'd0, dec_event}, 1);
    check("R7 dec after borrow", {32'd0, dec_value}, 64'hFFFF_FFFF);

    // Gated mode, pin low: tick count has no effect.
    tb_pin = 0; cyc(3);
    base = tb_value;
    dec_wr = 1; dec_wdata = 32'd100; cyc(1); dec_wr = 0;
    tick_count = 3; cyc(5); tick_count = 0;
    check("R5 tb frozen", tb_value, base);
    check("R5 dec frozen", {32'd0, dec_value}, 64'd100);

    // Edge mode: one count per pin rising edge, tick count ignored.
    ext_mode = 1; tick_count = 4;
    base = tb_value;
    for (int e = 0; e < 5; e++) begin
      tb_pin = 1; cyc(2);
      tb_pin = 0; cyc(2);
    end
    cyc(4);
    check("R6 tb edges", tb_value, base + 64'd5);
    check("R6 dec edges", {32'd0, dec_value}, 64'd95);
    tb_pin = 1; cyc(6);
    check("R6 held high single count", tb_value, base + 64'd6);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule